// File: doc/BRIEF.md
# Auto-Incrementing Display RAM Addresser

This block keeps the current write position inside a byte-wide display memory of 84 columns by 6 banks. Each data byte presented on the write strobe is stored at the current column/bank position. In that same clock the position steps to the next location. A mode input picks the stepping order. In column-first order the column counts up and carries into the bank. In bank-first order the bank counts up and carries into the column. At the far corner both coordinates return to zero.

The instruction decoder can load the column or the bank directly through two load strobes. A load value outside the geometry is dropped. When a load and a data write fall in the same cycle, the byte goes to the old position and the loaded coordinate wins over the stepped one. The block holds a small synchronous memory model with an independent read port, so a bench or a neighbouring block can inspect what was stored.

Top module: `pixel_ram_addresser`

## Requirements
- R1: While the active-low reset is asserted, and in the first cycle after it is released, the column and bank are 0 and the linear address is 0.
- R2: The column never exceeds 83 and the bank never exceeds 5.
- R3: The linear address output always equals bank*84 + column.
- R4: A write strobe in a cycle stores the data byte at that cycle's linear address. Presenting an address on the read port returns the stored byte on the read data output after the next rising clock edge.
- R5: With the mode input at 0 (column-first), each write moves the column up by one. From column 83 the column goes to 0 and the bank goes up by one.
- R6: In column-first order, a write at column 83, bank 5 moves the position to column 0, bank 0.
- R7: With the mode input at 1 (bank-first), each write moves the bank up by one. From bank 5 the bank goes to 0 and the column goes up by one.
- R8: In bank-first order, a write at column 83, bank 5 moves the position to column 0, bank 0.
- R9: A column load strobe with a value in 0..83 sets the column on the next edge. A bank load strobe with a value in 0..5 sets the bank on the next edge. Neither load writes memory.
- R10: A column load value above 83, or a bank load value above 5, is ignored. That coordinate keeps the value it would otherwise have had.
- R11: When a load and a write share a cycle, the byte is stored at the old position. The loaded coordinate takes the load value and the other coordinate takes its stepped value.
- R12: In a cycle with no write and no load, the position does not change.
- R13: A write strobe during reset stores nothing, and the position returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| vertMode | input | 1 | Stepping order: 0 column-first, 1 bank-first |
| wrValid | input | 1 | Store wrData at the current position and step |
| wrData | input | 8 | Data byte to store |
| setX | input | 1 | Load column from xValue |
| xValue | input | 7 | Column load value |
| setY | input | 1 | Load bank from yValue |
| yValue | input | 3 | Bank load value |
| rdAddr | input | 9 | Read port linear address |
| rdData | output | 8 | Byte at rdAddr, registered (0 beyond 503) |
| curX | output | 7 | Current column |
| curY | output | 3 | Current bank |
| curAddr | output | 9 | Current linear address |

## Verification
Checked every cycle by assertions:
- the coordinate bounds;
- single steps in each order away from the wrap points;
- a frozen position when the block is idle;
- dropped out-of-range column loads.

Only the bench's scenarios can show these behaviours:
- both corner wraps back to the origin;
- the carry between coordinates in each order;
- that stored bytes land at bank*84+column;
- how loads and writes in the same cycle resolve.

The bench fills all 504 locations and reads them back. It also shows that a write cut short by reset leaves memory untouched.

// File: rtl/pixel_addr_pkg.sv
package pixel_addr_pkg;

  // Strobes issued by the step control to the position datapath.
  typedef struct packed {
    logic writeEn;  // store the byte at the current position
    logic advX;     // column changes by stepping
    logic wrapX;    // stepping column returns to zero
    logic advY;     // bank changes by stepping
    logic wrapY;    // stepping bank returns to zero
    logic loadX;    // column takes the load value
    logic loadY;    // bank takes the load value
  } step_strobes_t;

endpackage

// File: rtl/addr_step_ctrl.sv
module addr_step_ctrl
  import pixel_addr_pkg::*;
#(
  parameter int COLS = 84,
  parameter int BANKS = 6,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(BANKS)
) (
  input  logic          wrValid,
  input  logic          vertMode,
  input  logic          setX,
  input  logic [XW-1:0] xValue,
  input  logic          setY,
  input  logic [YW-1:0] yValue,
  input  logic          xAtEnd,
  input  logic          yAtEnd,
  output step_strobes_t strobes
);

  localparam logic [XW-1:0] X_LAST = XW'(COLS - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(BANKS - 1);

  logic xLoadOk;
  logic yLoadOk;

  assign xLoadOk = setX && (xValue <= X_LAST);
  assign yLoadOk = setY && (yValue <= Y_LAST);

  always_comb begin
    strobes = '0;
    strobes.writeEn = wrValid;
    strobes.loadX = xLoadOk;
    strobes.loadY = yLoadOk;
    if (wrValid) begin
      if (!vertMode) begin
        // column-first: column steps, bank takes the carry
        strobes.advX = 1'b1;
        strobes.wrapX = xAtEnd;
        strobes.advY = xAtEnd;
        strobes.wrapY = xAtEnd && yAtEnd;
      end else begin
        // bank-first: bank steps, column takes the carry
        strobes.advY = 1'b1;
        strobes.wrapY = yAtEnd;
        strobes.advX = yAtEnd;
        strobes.wrapX = yAtEnd && xAtEnd;
      end
    end
  end

endmodule

// File: rtl/addr_pos_path.sv
module addr_pos_path
  import pixel_addr_pkg::*;
#(
  parameter int COLS = 84,
  parameter int BANKS = 6,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(BANKS),
  localparam int AW = $clog2(COLS * BANKS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  step_strobes_t strobes,
  input  logic [XW-1:0] xValue,
  input  logic [YW-1:0] yValue,
  output logic          xAtEnd,
  output logic          yAtEnd,
  output logic [XW-1:0] posX,
  output logic [YW-1:0] posY,
  output logic [AW-1:0] linAddr
);

  localparam logic [XW-1:0] X_LAST = XW'(COLS - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(BANKS - 1);
  localparam logic [AW-1:0] ROW_SPAN = AW'(COLS);

  logic [XW-1:0] nextX;
  logic [YW-1:0] nextY;

  assign xAtEnd = (posX == X_LAST);
  assign yAtEnd = (posY == Y_LAST);
  assign linAddr = AW'(posY) * ROW_SPAN + AW'(posX);

  always_comb begin
    nextX = posX;
    if (strobes.advX) nextX = strobes.wrapX ? '0 : posX + 1'b1;
    if (strobes.loadX) nextX = xValue;
  end

  always_comb begin
    nextY = posY;
    if (strobes.advY) nextY = strobes.wrapY ? '0 : posY + 1'b1;
    if (strobes.loadY) nextY = yValue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posX <= '0;
      posY <= '0;
    end else begin
      posX <= nextX;
      posY <= nextY;
    end
  end

  // R2
  x_range_chk: assert property (@(posedge clk) disable iff (!rstN) posX <= X_LAST);

  // R2
  y_range_chk: assert property (@(posedge clk) disable iff (!rstN) posY <= Y_LAST);

endmodule

// File: rtl/display_byte_ram.sv
module display_byte_ram #(
  parameter int DEPTH = 504,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrByte,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdByte
);

  logic [DW-1:0] store [DEPTH];

  // rstN gates the write so a byte cut short by reset is dropped
  always_ff @(posedge clk) begin
    if (wrEn && rstN && (int'(wrAddr) < DEPTH)) store[wrAddr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (int'(rdAddr) < DEPTH) rdByte <= store[rdAddr];
    else rdByte <= '0;
  end

endmodule

// File: rtl/pixel_ram_addresser.sv
module pixel_ram_addresser
  import pixel_addr_pkg::*;
#(
  parameter int COLS = 84,
  parameter int BANKS = 6,
  parameter int DW = 8,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(BANKS),
  localparam int AW = $clog2(COLS * BANKS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          vertMode,
  input  logic          wrValid,
  input  logic [DW-1:0] wrData,
  input  logic          setX,
  input  logic [XW-1:0] xValue,
  input  logic          setY,
  input  logic [YW-1:0] yValue,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic [XW-1:0] curX,
  output logic [YW-1:0] curY,
  output logic [AW-1:0] curAddr
);

  localparam logic [XW-1:0] X_LAST = XW'(COLS - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(BANKS - 1);

  step_strobes_t strobes;
  logic xAtEnd;
  logic yAtEnd;

  addr_step_ctrl #(.COLS(COLS), .BANKS(BANKS)) u_ctrl (
    .wrValid (wrValid),
    .vertMode(vertMode),
    .setX    (setX),
    .xValue  (xValue),
    .setY    (setY),
    .yValue  (yValue),
    .xAtEnd  (xAtEnd),
    .yAtEnd  (yAtEnd),
    .strobes (strobes)
  );

  addr_pos_path #(.COLS(COLS), .BANKS(BANKS)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .xValue (xValue),
    .yValue (yValue),
    .xAtEnd (xAtEnd),
    .yAtEnd (yAtEnd),
    .posX   (curX),
    .posY   (curY),
    .linAddr(curAddr)
  );

  display_byte_ram #(.DEPTH(COLS * BANKS), .DW(DW)) u_ram (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (strobes.writeEn),
    .wrAddr(curAddr),
    .wrByte(wrData),
    .rdAddr(rdAddr),
    .rdByte(rdData)
  );

  // R5
  horiz_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !vertMode && !setX && !setY && (curX != X_LAST)
    |=> (curX == XW'($past(curX) + 1'b1)) && (curY == $past(curY)));

  // R7
  vert_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && vertMode && !setX && !setY && (curY != Y_LAST)
    |=> (curY == YW'($past(curY) + 1'b1)) && (curX == $past(curX)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid && !setX && !setY |=> $stable(curX) && $stable(curY));

  // R10
  bad_xload_chk: assert property (@(posedge clk) disable iff (!rstN)
    setX && (xValue > X_LAST) && !wrValid |=> $stable(curX));

endmodule

// File: tb/pixel_ram_addresser_test.sv
module pixel_ram_addresser_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int COLS = 84;
  localparam int BANKS = 6;
  localparam int DEPTH = COLS * BANKS;

  logic clk = 1'b0;
  logic rstN;
  logic vertMode;
  logic wrValid;
  logic [7:0] wrData;
  logic setX;
  logic [6:0] xValue;
  logic setY;
  logic [2:0] yValue;
  logic [8:0] rdAddr;
  logic [7:0] rdData;
  logic [6:0] curX;
  logic [2:0] curY;
  logic [8:0] curAddr;

  always #10 clk = ~clk;  // 50 MHz

  pixel_ram_addresser uut (
    .clk(clk), .rstN(rstN), .vertMode(vertMode), .wrValid(wrValid),
    .wrData(wrData), .setX(setX), .xValue(xValue), .setY(setY),
    .yValue(yValue), .rdAddr(rdAddr), .rdData(rdData), .curX(curX),
    .curY(curY), .curAddr(curAddr)
  );

  typedef struct {
    int addr;
    int exp;
    string tag;
    int due;
  } rd_item_t;

  rd_item_t expQ[$];
  int checks = 0;
  int fails = 0;
  int cycleCount = 0;
  bit finished = 0;
  int mdlX = 0;
  int mdlY = 0;
  int mdlMem[DEPTH];

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkPos(input string tag);
    checkVal({tag, " column"}, int'(curX), mdlX);
    checkVal({tag, " bank"}, int'(curY), mdlY);
    checkVal({tag, " R3 address"}, int'(curAddr), mdlY * COLS + mdlX);
  endtask

  // driver: one clock of stimulus, model update, position check
  task automatic opCycle(input bit wv, input int d, input bit sx, input int xv,
                         input bit sy, input int yv, input string tag);
    int nx;
    int ny;
    wrValid = wv; wrData = 8'(d);
    setX = sx; xValue = 7'(xv);
    setY = sy; yValue = 3'(yv);
    nx = mdlX;
    ny = mdlY;
    if (wv) begin
      mdlMem[mdlY * COLS + mdlX] = d & 255;
      if (!vertMode) begin
        nx = mdlX + 1;
        if (nx == COLS) begin
          nx = 0;
          ny = mdlY + 1;
          if (ny == BANKS) ny = 0;
        end
      end else begin
        ny = mdlY + 1;
        if (ny == BANKS) begin
          ny = 0;
          nx = mdlX + 1;
          if (nx == COLS) nx = 0;
        end
      end
    end
    if (sx && xv < COLS) nx = xv;
    if (sy && yv < BANKS) ny = yv;
    mdlX = nx;
    mdlY = ny;
    @(negedge clk);
    wrValid = 0; setX = 0; setY = 0;
    checkPos(tag);
  endtask

  // driver: queue an expected read result for the monitor
  task automatic readBack(input int a, input string tag);
    rd_item_t it;
    rdAddr = 9'(a);
    it.addr = a;
    it.exp = mdlMem[a];
    it.tag = tag;
    it.due = cycleCount + 1;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor: pops expected read items once the read latency has passed
  always @(posedge clk) begin : monitor
    rd_item_t item;
    cycleCount++;
    #5;
    while (expQ.size() > 0 && expQ[0].due <= cycleCount) begin
      item = expQ.pop_front();
      checkVal({item.tag, " read"}, int'(rdData), item.exp);
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish();
  end

  initial begin
    int abortAddr;
    rstN = 0; vertMode = 0; wrValid = 0; wrData = 0;
    setX = 0; xValue = 0; setY = 0; yValue = 0; rdAddr = 0;
    repeat (3) @(negedge clk);
    checkPos("R1 in reset");
    rstN = 1;
    @(negedge clk);
    checkPos("R1 after reset");

    // column-first fill of every location; the last write wraps the corner
    for (int i = 0; i < DEPTH; i++)
      opCycle(1, i * 7 + 3, 0, 0, 0, 0, (i == DEPTH - 1) ? "R6" : "R5");
    for (int a = 0; a < DEPTH; a++) readBack(a, "R4");

    // idle cycles hold position
    for (int i = 0; i < 3; i++) opCycle(0, 0, 0, 0, 0, 0, "R12");

    // direct loads
    opCycle(0, 0, 1, 80, 1, 3, "R9");

    // bank-first run from (80,3) around the far corner
    vertMode = 1;
    for (int i = 0; i < 21; i++)
      opCycle(1, 200 + i, 0, 0, 0, 0, (i == 20) ? "R8" : "R7");
    for (int a = 0; a < DEPTH; a++) readBack(a, "R4");

    // out-of-range loads are dropped
    opCycle(0, 0, 0, 0, 1, 2, "R9");
    opCycle(0, 0, 1, 84, 0, 0, "R10");
    opCycle(0, 0, 0, 0, 1, 6, "R10");
    opCycle(0, 0, 1, 127, 1, 7, "R10");

    // loads sharing a cycle with writes
    vertMode = 0;
    opCycle(0, 0, 1, 83, 1, 2, "R9");
    opCycle(1, 8'hA5, 1, 5, 0, 0, "R11");
    vertMode = 1;
    opCycle(0, 0, 0, 0, 1, 5, "R9");
    opCycle(1, 8'h3C, 0, 0, 1, 0, "R11");
    opCycle(1, 8'hC3, 1, 90, 0, 0, "R10");
    readBack(2 * COLS + 83, "R11");
    readBack(5 * COLS + 5, "R11");
    readBack(0 * COLS + 6, "R10");

    // write strobe while reset is asserted stores nothing
    opCycle(0, 0, 1, 40, 1, 4, "R9");
    abortAddr = mdlY * COLS + mdlX;
    wrValid = 1; wrData = 8'hFF; rstN = 0;
    mdlX = 0; mdlY = 0;
    @(negedge clk);
    wrValid = 0;
    checkPos("R13");
    rstN = 1;
    @(negedge clk);
    readBack(abortAddr, "R13");
    readBack(0, "R13");

    repeat (4) @(negedge clk);
    finish();
  end

endmodule